// File: doc/BRIEF.md
# Gated-clock ADC frame sequencer

This block paces the reading of a serial analog-to-digital converter at a fixed sample rate. A frame counter, running on the system clock, splits each sample period into two parts. The first part is a conversion interval, during which chip select is released and the converter works. The second part is a read window. Inside that window, chip select is driven low and a serial clock is gated on for exactly as many pulses as one result has bits. Outside the window the serial clock stays low, so the converter never sees stray edges.

The serial clock runs at half the system clock with an even high/low split. The converter's data line is sampled MSB first at each rising serial clock edge. After the last bit, the assembled word is presented on a parallel output with a one-cycle strobe. The frame period, the conversion delay and the bit count are inputs. Each frame copies them once, at its boundary, so software can retune the block without producing a malformed frame.

Top module: `adc_frame_seq`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `cs_n` is 1, `sclk` is 0, `sample_vld` is 0 and `sample` is 0.
- R2: A frame lasts `frame_len` system clocks with bit 0 forced to zero, and never less than 2. Consecutive falling edges of `cs_n` are therefore that many cycles apart.
- R3: The first enabled cycle is frame cycle 0. In each frame, `cs_n` goes low at frame cycle `conv_len`+1 and stays low for 2×`bit_cnt` cycles, as long as the window fits in the frame.
- R4: Inside the window, `sclk` is low for one cycle and then high for one cycle, `bit_cnt` times. `sclk` is never high while `cs_n` is high, and it is never high for two consecutive cycles.
- R5: `sdi` is sampled at every system clock edge on which `sclk` rises. The first bit is the MSB. The word is right-aligned in `sample`, and the bits above the bit count are zero.
- R6: `sample_vld` pulses for exactly one cycle, the cycle in which `sclk` is high for the last bit. `sample` takes its new value in that cycle and holds it at all other times.
- R7: `frame_len`, `conv_len` and `bit_cnt` are copied at each frame boundary, and continuously while `en` is low. A change made in mid-frame first affects the next frame.
- R8: A `bit_cnt` of 0 produces no window, no `sclk` pulse and no strobe. A `bit_cnt` larger than `DATA_W` acts as `DATA_W`.
- R9: When `en` is low, the frame counter is held at zero, and `cs_n`/`sclk` are idle on the next cycle. On re-enable, the frame restarts aligned at frame cycle 0.
- R10: A window that does not fit in the frame is cut off at the frame boundary, and no strobe is produced for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the frame counter at zero |
| frame_len | input | CNT_W | Frame period in system clocks (rounded down to even) |
| conv_len | input | CNT_W | Conversion delay from frame start to window start |
| bit_cnt | input | BW | Bits per sample (clamped to DATA_W) |
| sdi | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Chip select, active low during the read window |
| sclk | output | 1 | Gated serial clock |
| sample | output | DATA_W | Last assembled word, right-aligned |
| sample_vld | output | 1 | One-cycle strobe when `sample` updates |

## Verification
The bench looks for the following corner cases:
- An odd frame length. A design that kept bit 0 would stretch every frame by one cycle.
- A bit count changed while a window is open. A design that read it live would emit a frame with the wrong number of pulses.
- A zero bit count, which an off-by-one window compare would turn into a wrapped, nearly endless window.
- An oversize bit count, which an unclamped design would use to overrun the shift register.
- A window longer than the frame. A design that did not cut it at the boundary would strobe a half-assembled word.
- Re-enabling in mid-frame. An unaligned restart would shift the first chip-select edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // Per-cycle decode of where the frame counter sits relative to the window
    typedef struct packed {
        logic win;         // inside the read window
        logic rise;        // serial clock rises at this edge
        logic first_rise;  // first bit of the word
        logic last_rise;   // last bit of the word
    } gate_t;

    // Round a period down to a whole number of serial clock periods (2 clocks), minimum one
    function automatic logic [31:0] round_period(input logic [31:0] len);
        logic [31:0] r;
        r = {len[31:1], 1'b0};
        return (r < 32'd2) ? 32'd2 : r;
    endfunction

    function automatic logic [31:0] clamp_bits(input logic [31:0] b, input logic [31:0] lim);
        return (b > lim) ? lim : b;
    endfunction

endpackage

// File: rtl/adc_seq_frame.sv
module adc_seq_frame
    import adc_seq_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int DATA_W = 16,
    parameter int BW     = $clog2(DATA_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] frame_len,
    input  logic [CNT_W-1:0] conv_len,
    input  logic [BW-1:0]    bit_cnt,
    output gate_t            gate
);
    localparam int CW = CNT_W + 2;

    logic [CNT_W-1:0] fc_q, per_q, conv_q, last_idx;
    logic [BW-1:0]    bits_q;
    logic [CNT_W-1:0] per_n;
    logic [BW-1:0]    bits_n;
    logic [CW-1:0]    off, span;
    logic             wrap;

    assign per_n    = CNT_W'(round_period(32'(frame_len)));
    assign bits_n   = BW'(clamp_bits(32'(bit_cnt), 32'(DATA_W)));
    assign last_idx = per_q - 1'b1;
    assign wrap     = (fc_q == last_idx);

    assign off  = CW'(fc_q) - CW'(conv_q);
    assign span = CW'(bits_q) << 1;

    always_comb begin
        gate.win        = en && (fc_q >= conv_q) && (off < span);
        gate.rise       = gate.win && off[0];
        gate.first_rise = gate.win && (off == CW'(1));
        gate.last_rise  = gate.win && (off == span - CW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || !en || wrap) begin
            fc_q   <= '0;
            per_q  <= per_n;
            conv_q <= conv_len;
            bits_q <= bits_n;
        end else begin
            fc_q <= fc_q + 1'b1;
        end
    end

    assert_fc_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        fc_q <= last_idx);

    assert_hold_when_off_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (fc_q == '0));

endmodule

// File: rtl/adc_seq_clkgate.sv
module adc_seq_clkgate (
    input  logic clk,
    input  logic rst,
    input  logic win,
    input  logic rise,
    output logic cs_n,
    output logic sclk
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n <= 1'b1;
            sclk <= 1'b0;
        end else begin
            cs_n <= !win;
            sclk <= rise;
        end
    end

    assert_sclk_inside_cs_R4: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !cs_n);

    assert_sclk_half_rate_R4: assert property (@(posedge clk) disable iff (rst)
        sclk |=> !sclk);

endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic              first_rise,
    input  logic              last_rise,
    input  logic              sdi,
    output logic [DATA_W-1:0] sample,
    output logic              sample_vld
);
    logic [DATA_W-1:0] sh_q, nxt;

    assign nxt = first_rise ? {{(DATA_W-1){1'b0}}, sdi} : {sh_q[DATA_W-2:0], sdi};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q       <= '0;
            sample     <= '0;
            sample_vld <= 1'b0;
        end else begin
            sample_vld <= 1'b0;
            if (rise) begin
                sh_q <= nxt;
                if (last_rise) begin
                    sample     <= nxt;
                    sample_vld <= 1'b1;
                end
            end
        end
    end

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst)
        sample_vld |=> !sample_vld);

    assert_sample_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(sample) |-> sample_vld);

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
    import adc_seq_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int DATA_W = 16,
    parameter int BW     = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [CNT_W-1:0]  frame_len,
    input  logic [CNT_W-1:0]  conv_len,
    input  logic [BW-1:0]     bit_cnt,
    input  logic              sdi,
    output logic              cs_n,
    output logic              sclk,
    output logic [DATA_W-1:0] sample,
    output logic              sample_vld
);
    gate_t gate;

    adc_seq_frame #(.CNT_W(CNT_W), .DATA_W(DATA_W), .BW(BW)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .frame_len (frame_len),
        .conv_len  (conv_len),
        .bit_cnt   (bit_cnt),
        .gate      (gate)
    );

    adc_seq_clkgate u_gate (
        .clk  (clk),
        .rst  (rst),
        .win  (gate.win),
        .rise (gate.rise),
        .cs_n (cs_n),
        .sclk (sclk)
    );

    adc_seq_capture #(.DATA_W(DATA_W)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .rise       (gate.rise),
        .first_rise (gate.first_rise),
        .last_rise  (gate.last_rise),
        .sdi        (sdi),
        .sample     (sample),
        .sample_vld (sample_vld)
    );

endmodule

// File: tb/sim_adc_frame_seq.sv
module sim_adc_frame_seq;
    localparam int CNT_W  = 12;
    localparam int DATA_W = 16;
    localparam int BW     = $clog2(DATA_W + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic [CNT_W-1:0] frame_len = 40;
    logic [CNT_W-1:0] conv_len = 5;
    logic [BW-1:0] bit_cnt = 16;
    logic sdi = 1'b0;
    logic cs_n, sclk, sample_vld;
    logic [DATA_W-1:0] sample;

    always #10 clk = ~clk;

    adc_frame_seq #(.CNT_W(CNT_W), .DATA_W(DATA_W), .BW(BW)) u0 (
        .clk(clk), .rst(rst), .en(en), .frame_len(frame_len), .conv_len(conv_len),
        .bit_cnt(bit_cnt), .sdi(sdi), .cs_n(cs_n), .sclk(sclk), .sample(sample),
        .sample_vld(sample_vld)
    );

    int vecs = 0;
    int fails = 0;
    int cyc = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int m_fc = 0, m_len = 2, m_conv = 0, m_bits = 0;
    logic [15:0] m_sh = '0;
    logic e_cs = 1'b1, e_sclk = 1'b0, e_vld = 1'b0;
    logic [15:0] e_smp = '0;
    bit mdl_ok = 0;

    task automatic mdl_load();
        m_len = int'(frame_len) & ~1;
        if (m_len < 2) m_len = 2;
        m_conv = int'(conv_len);
        m_bits = (int'(bit_cnt) > DATA_W) ? DATA_W : int'(bit_cnt);
    endtask

    always @(posedge clk) begin
        bit win;
        int k;
        if (rst) begin
            e_cs = 1'b1; e_sclk = 1'b0; e_vld = 1'b0; e_smp = '0; m_sh = '0; m_fc = 0;
            mdl_load();
        end else begin
            k = m_fc - m_conv;
            win = en && (m_fc >= m_conv) && (k < 2 * m_bits);
            e_cs = !win;
            e_sclk = win && (k % 2 == 1);
            e_vld = 1'b0;
            if (e_sclk) begin
                m_sh = (k == 1) ? {15'b0, sdi} : {m_sh[14:0], sdi};
                if (k == 2 * m_bits - 1) begin
                    e_smp = m_sh;
                    e_vld = 1'b1;
                end
            end
            if (!en || m_fc == m_len - 1) begin
                m_fc = 0;
                mdl_load();
            end else begin
                m_fc++;
            end
        end
        mdl_ok = 1;
    end

    always @(negedge clk) begin
        if (mdl_ok) begin
            chk("R3 cs_n per-cycle", 32'(cs_n), 32'(e_cs));
            chk("R4 sclk per-cycle", 32'(sclk), 32'(e_sclk));
            chk("R6 sample_vld per-cycle", 32'(sample_vld), 32'(e_vld));
            chk("R5 sample per-cycle", 32'(sample), 32'(e_smp));
        end
    end

    // Window monitor
    logic prev_cs = 1'b1;
    int low_run = 0, pulse_run = 0, last_low = 0, last_pulses = 0;
    int win_ends = 0, fall_cyc = -1, last_period = 0, vld_cnt = 0, low_total = 0;
    int ncyc = 0;
    logic [15:0] last_sample = '0;

    always @(negedge clk) begin
        if (!cs_n) begin
            low_run++;
            low_total++;
            if (sclk) pulse_run++;
        end
        if (cs_n && !prev_cs) begin
            last_low = low_run; last_pulses = pulse_run;
            low_run = 0; pulse_run = 0; win_ends++;
        end
        if (!cs_n && prev_cs) begin
            if (fall_cyc >= 0) last_period = ncyc - fall_cyc;
            fall_cyc = ncyc;
        end
        if (sample_vld) begin
            vld_cnt++;
            last_sample = sample;
        end
        ncyc++;
        prev_cs = cs_n;
    end

    // Converter model: presents the word MSB first, or pseudo-random bits
    bit adc_mode = 1;
    logic [15:0] word = 16'hA5C3;
    logic [15:0] lfsr = 16'hACE1;
    initial begin
        int idx;
        int eb;
        idx = 0;
        forever begin
            @(negedge clk);
            if (adc_mode) begin
                if (cs_n) idx = 0;
                else if (sclk) idx++;
                eb = (int'(bit_cnt) > DATA_W) ? DATA_W : int'(bit_cnt);
                sdi = (idx < eb) ? word[eb - 1 - idx] : 1'b0;
            end else begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                sdi = lfsr[0];
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL R9 watchdog actual=%0d expected<%0d", cyc, 100000);
            summary();
            $finish;
        end
    end

    task automatic wait_ends(input int n);
        int w;
        w = win_ends;
        while (win_ends < w + n) @(posedge clk);
    endtask

    task automatic reconfig(input int fl, input int cv, input int bc);
        @(negedge clk);
        en = 1'b0;
        frame_len = CNT_W'(fl);
        conv_len = CNT_W'(cv);
        bit_cnt = BW'(bc);
        @(negedge clk);
        en = 1'b1;
    endtask

    initial begin
        int n;
        int v0, l0, e0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 cs_n reset", 32'(cs_n), 32'd1);
        chk("R1 sclk reset", 32'(sclk), 32'd0);
        chk("R1 sample_vld reset", 32'(sample_vld), 32'd0);
        chk("R1 sample reset", 32'(sample), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        en = 1'b1;

        // Config A: 40-cycle frame, 5-cycle conversion, 16 bits
        wait_ends(3);
        chk("R2 period A", 32'(last_period), 32'd40);
        chk("R3 window A", 32'(last_low), 32'd32);
        chk("R4 pulses A", 32'(last_pulses), 32'd16);
        chk("R5 word A", 32'(last_sample), 32'hA5C3);

        // Config B: odd length 27 -> 26, 10 bits
        word = 16'h02B7;
        reconfig(27, 3, 10);
        wait_ends(3);
        chk("R2 period odd", 32'(last_period), 32'd26);
        chk("R3 window B", 32'(last_low), 32'd20);
        chk("R4 pulses B", 32'(last_pulses), 32'd10);
        chk("R5 word B right-aligned", 32'(last_sample), 32'h02B7);

        // R9: drop enable, then restart aligned
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk("R9 cs_n idle", 32'(cs_n), 32'd1);
        chk("R9 sclk idle", 32'(sclk), 32'd0);
        en = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (cs_n && n < 100);
        chk("R9 restart first cs low", 32'(n), 32'd4);

        // R7: change bit count while a window is open
        adc_mode = 0;
        @(posedge clk);
        while (cs_n) @(posedge clk);
        @(negedge clk);
        bit_cnt = 4;
        wait_ends(1);
        chk("R7 current frame keeps count", 32'(last_pulses), 32'd10);
        wait_ends(1);
        chk("R7 next frame new count", 32'(last_pulses), 32'd4);

        // R8: zero bit count
        reconfig(30, 4, 0);
        repeat (2) @(negedge clk);
        v0 = vld_cnt; l0 = low_total; e0 = win_ends;
        repeat (100) @(negedge clk);
        chk("R8 zero bits no cs", 32'(low_total - l0), 32'd0);
        chk("R8 zero bits no strobe", 32'(vld_cnt - v0), 32'd0);
        chk("R8 zero bits no window", 32'(win_ends - e0), 32'd0);

        // R8: oversize bit count clamps
        adc_mode = 1;
        word = 16'h1234;
        reconfig(50, 2, 20);
        wait_ends(3);
        chk("R8 clamp pulses", 32'(last_pulses), 32'd16);
        chk("R8 clamp window", 32'(last_low), 32'd32);
        chk("R2 period C", 32'(last_period), 32'd50);
        chk("R5 word C", 32'(last_sample), 32'h1234);

        // R10: window overruns frame
        adc_mode = 0;
        reconfig(20, 10, 8);
        @(negedge clk);
        v0 = vld_cnt;
        wait_ends(3);
        chk("R10 truncated window", 32'(last_low), 32'd10);
        chk("R10 no strobe", 32'(vld_cnt - v0), 32'd0);

        repeat (5) @(negedge clk);
        summary();
        $finish;
    end

endmodule